// File: doc/BRIEF.md
# Three-Wire Serial Register Read Slave

This block is the target side of a three-wire control port. The port has an active-low select, a serial clock driven by the master and one shared data line. The block samples all three pins with its own system clock through a short synchronizer. It detects the edges of the serial clock and runs a frame engine that shifts in a 4-bit address and a direction flag. For a read, it then takes over the data line and shifts the chosen register out, most significant bit first.

The register file has sixteen address slots. A parameter table gives each slot a width of 1 to 32 bits, and a width of 0 marks the slot as absent. The block defines what the master sees when it clocks past the end of a register, when it addresses an absent slot and when it releases the select in the middle of a frame. A write frame shifts bits into a holding register. The target register is updated when the select is released, and only if the frame was well formed.

Top module: `serial_reg_slave`

## Requirements
- R1: While select is low, the first four rising serial-clock edges capture the address MSB first (the first bit is address bit 3). The fifth rising edge captures the direction flag.
- R2: A direction flag of 0 starts a read. The data-line enable stays low through the high phase of the flag bit and goes high on the next falling serial-clock edge.
- R3: In a read, the data line changes only on falling serial-clock edges. The k-th falling edge (k counted from 0) presents register bit width-1-k, so the value is stable before the following rising edge. Outputs follow pin edges within four system-clock cycles.
- R4: In a read of a valid register, every bit clocked beyond its width is driven as 0.
- R5: In a read of an absent address, the data line is 1 for the first 32 data-phase periods and 0 for every later period.
- R6: Raising select at any point drops the data-line enable and returns the frame engine to the address phase. When select rises in the same sampling as a falling serial-clock edge, the release takes priority.
- R7: A direction flag of 1 starts a write. Bits are taken MSB first on rising edges and the data-line enable stays low. The target register is updated when select rises, and only if the address is valid and exactly its width in bits was received.
- R8: The default width table is address 0:10, 1:8, 2:16, 3:32, 4:1, 5:24, 6:12, 7:4, 8:31, 9:20. Addresses 10 to 15 are absent. On reset, register a holds ({8{a}} xor 32'h5A5A5A5A) truncated to its width.
- R9: After reset, the data-line enable and the data output are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the pins |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Active-low frame select from the master |
| sck_i | input | 1 | Serial clock from the master |
| sdata_i | input | 1 | Data line as seen by the input buffer |
| sdata_o | output | 1 | Value driven onto the data line |
| sdata_oe_o | output | 1 | High while the block drives the data line |

## Verification
The release of select and a falling serial-clock edge can both arrive in the same synchronized sample. At that point the shift-out logic wants to drive the next bit while the release logic wants to turn the line around. The bench provokes this by raising select and lowering the clock on the same system-clock edge partway through a read. It judges the result by checking that the enable is low afterwards and that the next frame reads every bit of a register correctly from its MSB. A write frame released on its final rising edge gives a second overlap, between the commit and the counter reset; the read-back sweep judges it.

// File: rtl/serial_reg_slave_pkg.sv
package serial_reg_slave_pkg;

    localparam int ADDR_W       = 4;
    localparam int NUM_REGS     = 1 << ADDR_W;
    localparam int DATA_W       = 32;
    localparam int WID_W        = $clog2(DATA_W + 1);
    localparam int CNT_W        = 6;
    localparam int HDR_BITS     = ADDR_W;
    localparam int ABSENT_SPAN  = 32;
    localparam int TAB_W        = NUM_REGS * WID_W;

    typedef enum logic [1:0] {
        PH_ADDR  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_t;

    typedef struct packed {
        phase_t             phase;
        logic [ADDR_W-1:0]  addr;
        logic [CNT_W-1:0]   cnt;
        logic [DATA_W-1:0]  hold;
    } frame_t;

    localparam frame_t FRAME_IDLE = '{phase: PH_ADDR, addr: '0, cnt: '0, hold: '0};

    function automatic logic [WID_W-1:0] width_at(input logic [TAB_W-1:0] tab,
                                                  input int unsigned idx);
        return tab[idx*WID_W +: WID_W];
    endfunction

    function automatic logic width_ok(input logic [WID_W-1:0] w);
        return (w != '0) && (int'(w) <= DATA_W);
    endfunction

    function automatic logic [DATA_W-1:0] mask_of(input logic [WID_W-1:0] w);
        logic [DATA_W-1:0] m;
        if (!width_ok(w))            m = '0;
        else if (int'(w) >= DATA_W)  m = '1;
        else                         m = (DATA_W'(1) << w) - DATA_W'(1);
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] init_val(input int unsigned idx);
        logic [ADDR_W-1:0] a;
        a = ADDR_W'(idx);
        return {8{a}} ^ 32'h5A5A_5A5A;
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
        return (c == '1) ? c : c + CNT_W'(1);
    endfunction

    function automatic logic read_bit(input logic              valid,
                                      input logic [WID_W-1:0]  w,
                                      input logic [CNT_W-1:0]  idx,
                                      input logic [DATA_W-1:0] data);
        logic [CNT_W-1:0] pos;
        logic             b;
        pos = CNT_W'(w) - idx - CNT_W'(1);
        if (!valid)                       b = (int'(idx) < ABSENT_SPAN);
        else if (CNT_W'(w) > idx)         b = data[pos[$clog2(DATA_W)-1:0]];
        else                              b = 1'b0;
        return b;
    endfunction

endpackage

// File: rtl/srs_pin_sync.sv
module srs_pin_sync #(
    parameter int          STAGES    = 2,
    parameter int          N         = 3,
    parameter logic [N-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    logic [N-1:0] stage [STAGES+1];
    logic [N-1:0] prev;

    assign stage[0] = raw;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[s+1] <= RESET_VAL;
            else     stage[s+1] <= stage[s];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= RESET_VAL;
        else     prev <= stage[STAGES];
    end

    assign level = stage[STAGES];
    assign rise  = stage[STAGES] & ~prev;
    assign fall  = ~stage[STAGES] & prev;

endmodule

// File: rtl/srs_reg_bank.sv
module srs_reg_bank
    import serial_reg_slave_pkg::*;
#(
    parameter logic [TAB_W-1:0] WIDTH_TABLE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [WID_W-1:0]  W    = width_at(WIDTH_TABLE, i);
        localparam logic [DATA_W-1:0] MASK = mask_of(W);
        logic [DATA_W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst)                                  q <= init_val(i) & MASK;
            else if (wr_en && wr_addr == ADDR_W'(i))  q <= wr_data & MASK;
        end

        assign regs[i] = q;
    end

    assign rd_data = regs[rd_addr];

    // R7: contents move only in the cycle after a commit strobe
    a_r7_bank_quiet: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs));

endmodule

// File: rtl/srs_frame_ctrl.sv
module srs_frame_ctrl
    import serial_reg_slave_pkg::*;
#(
    parameter logic [TAB_W-1:0] WIDTH_TABLE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_hi,
    input  logic              sel_rise,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              oe
);

    frame_t           fr, fr_nx;
    logic             sdo_q, oe_q;
    logic             sdo_nx, oe_nx;
    logic [WID_W-1:0] cur_w;
    logic             cur_ok;

    assign cur_w  = width_at(WIDTH_TABLE, int'(fr.addr));
    assign cur_ok = width_ok(cur_w);

    always_comb begin
        fr_nx  = fr;
        sdo_nx = sdo_q;
        oe_nx  = oe_q;
        if (sel_hi) begin
            fr_nx  = FRAME_IDLE;
            sdo_nx = 1'b0;
            oe_nx  = 1'b0;
        end else begin
            unique case (fr.phase)
                PH_ADDR: begin
                    if (sck_rise) begin
                        if (int'(fr.cnt) < HDR_BITS) begin
                            fr_nx.addr = {fr.addr[ADDR_W-2:0], sdi};
                            fr_nx.cnt  = fr.cnt + CNT_W'(1);
                        end else begin
                            fr_nx.phase = sdi ? PH_WRITE : PH_READ;
                            fr_nx.cnt   = '0;
                            fr_nx.hold  = '0;
                        end
                    end
                end
                PH_READ: begin
                    if (sck_fall) begin
                        sdo_nx    = read_bit(cur_ok, cur_w, fr.cnt, rd_data);
                        oe_nx     = 1'b1;
                        fr_nx.cnt = sat_inc(fr.cnt);
                    end
                end
                PH_WRITE: begin
                    if (sck_rise) begin
                        fr_nx.hold = {fr.hold[DATA_W-2:0], sdi};
                        fr_nx.cnt  = sat_inc(fr.cnt);
                    end
                end
                default: fr_nx = FRAME_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fr    <= FRAME_IDLE;
            sdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            fr    <= fr_nx;
            sdo_q <= sdo_nx;
            oe_q  <= oe_nx;
        end
    end

    assign wr_en   = sel_rise && (fr.phase == PH_WRITE) && cur_ok &&
                     (fr.cnt == CNT_W'(cur_w));
    assign wr_addr = fr.addr;
    assign wr_data = fr.hold;
    assign rd_addr = fr.addr;
    assign sdo     = sdo_q;
    assign oe      = oe_q;

    // R6: a released select turns the line around on the next cycle
    a_r6_release_drops_oe: assert property (@(posedge clk) disable iff (rst)
        sel_hi |=> !oe_q);

    // R1: a released select leaves the engine at the start of the address phase
    a_r1_release_restarts: assert property (@(posedge clk) disable iff (rst)
        sel_hi |=> (fr.phase == PH_ADDR) && (fr.cnt == '0));

    // R2: the line is only ever taken over on a falling serial-clock edge
    a_r2_turn_on_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_q) |-> $past(sck_fall) && !$past(sel_hi));

    // R4: past the register width the line carries zero
    a_r4_overread_zero: assert property (@(posedge clk) disable iff (rst)
        (!sel_hi && sck_fall && fr.phase == PH_READ && cur_ok &&
         fr.cnt >= CNT_W'(cur_w)) |=> !sdo_q);

    // R5: an absent address answers with ones for the first span
    a_r5_absent_ones: assert property (@(posedge clk) disable iff (rst)
        (!sel_hi && sck_fall && fr.phase == PH_READ && !cur_ok &&
         int'(fr.cnt) < ABSENT_SPAN) |=> sdo_q);

    // R7: a write frame never drives the line
    a_r7_write_silent: assert property (@(posedge clk) disable iff (rst)
        (fr.phase == PH_WRITE) |-> !oe_q);

endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
    import serial_reg_slave_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [TAB_W-1:0] WIDTH_TABLE = {
        6'd0,  6'd0,  6'd0,  6'd0,  6'd0,  6'd0,
        6'd20, 6'd31, 6'd4,  6'd12, 6'd24, 6'd1,
        6'd32, 6'd16, 6'd8,  6'd10
    }
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_n_i,
    input  logic sck_i,
    input  logic sdata_i,
    output logic sdata_o,
    output logic sdata_oe_o
);

    localparam int PIN_SEL = 2;
    localparam int PIN_SCK = 1;
    localparam int PIN_DAT = 0;

    logic [2:0]        lvl, rise, fall;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    srs_pin_sync #(
        .STAGES    (SYNC_STAGES),
        .N         (3),
        .RESET_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   ({sel_n_i, sck_i, sdata_i}),
        .level (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    srs_frame_ctrl #(
        .WIDTH_TABLE (WIDTH_TABLE)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sel_hi   (lvl[PIN_SEL]),
        .sel_rise (rise[PIN_SEL]),
        .sck_rise (rise[PIN_SCK]),
        .sck_fall (fall[PIN_SCK]),
        .sdi      (lvl[PIN_DAT]),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sdo      (sdata_o),
        .oe       (sdata_oe_o)
    );

    srs_reg_bank #(
        .WIDTH_TABLE (WIDTH_TABLE)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // R9: nothing is driven while the block is held in reset
    a_r9_quiet_in_reset: assert property (@(posedge clk)
        $past(rst) |-> !sdata_oe_o && !sdata_o);

    // R6: enable is low whenever the synchronized select is high for two samples
    a_r6_idle_undriven: assert property (@(posedge clk) disable iff (rst)
        (lvl[PIN_SEL] && $past(lvl[PIN_SEL])) |-> !sdata_oe_o);

endmodule

// File: tb/sim_serial_reg_slave.sv
module sim_serial_reg_slave;

    localparam int H = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_n = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic sdo, oe;

    int checks = 0;
    int errs   = 0;
    logic [31:0] mdl [16];

    always #10 clk = ~clk;

    serial_reg_slave u0 (
        .clk        (clk),
        .rst        (rst),
        .sel_n_i    (sel_n),
        .sck_i      (sck),
        .sdata_i    (sdi),
        .sdata_o    (sdo),
        .sdata_oe_o (oe)
    );

    function automatic int bw(input int a);
        case (a)
            0: return 10;  1: return 8;   2: return 16;  3: return 32;
            4: return 1;   5: return 24;  6: return 12;  7: return 4;
            8: return 31;  9: return 20;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] bmask(input int w);
        if (w <= 0) return 32'h0;
        if (w >= 32) return 32'hFFFF_FFFF;
        return (32'h1 << w) - 32'h1;
    endfunction

    function automatic logic exp_bit(input int a, input int k);
        int w;
        w = bw(a);
        if (w == 0) return (k < 32);
        if (k < w) return mdl[a][w-1-k];
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sck = 1'b0; sdi = b;
        waitc(H);
        sck = 1'b1;
        waitc(H);
    endtask

    task automatic send_hdr(input int a, input logic rw);
        sel_n = 1'b0;
        waitc(H);
        for (int i = 3; i >= 0; i--) send_bit(a[i]);
        send_bit(rw);
    endtask

    // mode 0: release while clock high; mode 1: release together with a falling edge
    task automatic read_frame(input int a, input int nbits, input int mode);
        send_hdr(a, 1'b0);
        chk(oe == 1'b0, "R2 enable low during flag bit", 32'(oe), 32'h0);
        for (int k = 0; k < nbits; k++) begin
            sck = 1'b0;
            waitc(H - 1);
            chk(oe == 1'b1, "R2 enable high after falling edge", 32'(oe), 32'h1);
            chk(sdo == exp_bit(a, k),
                (bw(a) == 0) ? "R5 absent address pattern" :
                (k >= bw(a)) ? "R4 over-read zero" : "R3 R1 R8 data bit MSB first",
                32'(sdo), 32'(exp_bit(a, k)));
            waitc(1);
            sck = 1'b1;
            waitc(H);
        end
        if (mode == 1) begin
            sck = 1'b0; sel_n = 1'b1;
        end else begin
            sel_n = 1'b1;
            waitc(H);
            sck = 1'b0;
        end
        waitc(H);
        chk(oe == 1'b0, "R6 enable dropped after release", 32'(oe), 32'h0);
    endtask

    task automatic write_frame(input int a, input logic [31:0] data, input int nbits);
        send_hdr(a, 1'b1);
        for (int i = nbits - 1; i >= 0; i--) send_bit(data[i]);
        chk(oe == 1'b0, "R7 no drive in write", 32'(oe), 32'h0);
        sel_n = 1'b1;
        waitc(H);
        sck = 1'b0;
        waitc(H);
        if (bw(a) != 0 && nbits == bw(a)) mdl[a] = data & bmask(bw(a));
    endtask

    task automatic addr_abort(input int a, input int nbits);
        sel_n = 1'b0;
        waitc(H);
        for (int i = 3; i >= 4 - nbits; i--) send_bit(a[i]);
        sel_n = 1'b1;
        waitc(H);
        sck = 1'b0;
        waitc(H);
        chk(oe == 1'b0, "R6 undriven after header abort", 32'(oe), 32'h0);
    endtask

    task automatic sweep();
        for (int a = 0; a < 16; a++)
            read_frame(a, (bw(a) == 0) ? 36 : bw(a) + 3, 0);
    endtask

    initial begin
        repeat (1_000_000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < 16; a++)
            mdl[a] = ({8{a[3:0]}} ^ 32'h5A5A_5A5A) & bmask(bw(a));
        waitc(4);
        chk(oe == 1'b0 && sdo == 1'b0, "R9 reset outputs", {30'h0, oe, sdo}, 32'h0);
        rst = 1'b0;
        waitc(4);
        chk(oe == 1'b0, "R9 idle after reset", 32'(oe), 32'h0);

        // R8 R3 R4 R5: reset contents of every slot, over-read tails included
        sweep();

        // R7: exact-length writes land, short and long writes are dropped
        for (int a = 0; a < 16; a++) begin
            logic [31:0] pat;
            pat = 32'hC3A5_1E69 ^ (32'(a) * 32'h1111_1111);
            if (bw(a) > 1) write_frame(a, ~pat, bw(a) - 1);
            write_frame(a, pat, (bw(a) == 0) ? 8 : bw(a));
            write_frame(a, ~pat, ((bw(a) == 0) ? 8 : bw(a)) + 1);
        end
        sweep();

        // R6: abort a read after three bits, then read the same slot from its MSB
        read_frame(3, 3, 0);
        read_frame(3, 32, 0);
        // R1 R6: abort inside the address phase, next frame decodes cleanly
        addr_abort(8, 2);
        read_frame(2, 16, 0);
        // R6: release coincides with a falling edge
        read_frame(5, 7, 1);
        read_frame(5, 24, 0);
        read_frame(12, 33, 1);
        read_frame(9, 20, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule